// File: doc/BRIEF.md
# Per-Line Input Glitch and Debounce Filter

This block conditions 32 asynchronous input lines before their levels are reported to software. Each line is first brought into the master clock domain by a two-flop synchroniser. It can then be passed straight through, or it can be routed through one of two filters. The glitch filter runs on the master clock and drops any pulse that lasts only one master sample. The debounce filter runs on a divided slow clock and only accepts a new level once that level has been seen on two consecutive rising edges of the divided clock. The filtered level of every line is held in a pin-level register, which reports the line state whatever drives the line.

Software controls each line with two bits: a filter enable and a filter selection (0 = glitch, 1 = debounce). Each bit is changed only by writing one-hot masks to separate set and clear addresses, and the current value can be read back. The debounce sampling rate comes from a built-in divider that counts pulses of a slow-clock tick input. When the controller clock enable is low, the whole filter path stops and the pin-level register keeps the levels it held when the clock stopped.

Top module: `pin_input_filter`

## Requirements
- R1: After reset, `filt_en`, `filt_sel`, `div_val` and `pin_level` are all zero.
- R2: A write to address 0 sets, and a write to address 1 clears, every `filt_en` bit that is 1 in `wr_data`. All other bits are left unchanged, and the result is visible on the next cycle.
- R3: A write to address 2 sets, and a write to address 3 clears, the `filt_sel` bits given by `wr_data`. No other address and no idle cycle changes `filt_sel`.
- R4: A line whose enable bit is 0 bypasses both filters. A level change on `raw_in` is not yet visible two cycles after it is applied and appears on `pin_level` on the third rising clock edge.
- R5: A line with enable 1 and select 0 uses the glitch filter. A pulse lasting one master cycle never reaches `pin_level`. A level held steady appears on the fifth rising edge after it is applied.
- R6: A line with enable 1 and select 1 uses the debounce filter. A new level reaches `pin_level` only after it has been sampled at two consecutive rising edges of the divided clock. A pulse shorter than one divided period is rejected.
- R7: `div_clk` toggles after every DIV+1 `slow_tick` pulses, so its rising edges are 2*(DIV+1) ticks apart.
- R8: While `clk_en` is 0, `pin_level` holds its value whatever `raw_in` does. Once `clk_en` is 1 again, it follows the inputs.
- R9: Every line is filtered independently according to its own enable and select bits. Once all inputs have been steady long enough, `pin_level` equals `raw_in` on every line.
- R10: A write to address 4 loads DIV from `wr_data[13:0]` and ignores the upper bits. The value reads back on `div_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Controller clock enable; 0 freezes the filter path |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| raw_in | input | 32 | Asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 enable set, 1 enable clear, 2 select set, 3 select clear, 4 divider |
| wr_data | input | 32 | Write data / bit mask |
| pin_level | output | 32 | Filtered line levels |
| filt_en | output | 32 | Per-line filter enable readback |
| filt_sel | output | 32 | Per-line selection readback (1 = debounce) |
| div_val | output | 14 | Divider field readback |
| div_clk | output | 1 | Divided slow clock |

## Verification
Several properties are checked on every cycle. They cover set/clear masking and the hold of the configuration, the freeze of each lane when the clock enable is low, and the one-cycle bypass path. They also check that the glitch output moves only after two equal synchronised samples and that the debounce output moves only on a divider strobe with a matching sample. Other behaviour is shown only by the bench scenarios: the absolute latencies, whether pulses shorter than a window are rejected, the divided-clock period for different divider values, and whether mixed random configurations settle to the raw levels.

// File: rtl/pin_filter_pkg.sv
`timescale 1ns/1ps
package pin_filter_pkg;
    localparam int LINES_DEF = 32;
    localparam int DIVW_DEF  = 14;

    typedef enum logic [2:0] {
        ADDR_EN_SET  = 3'd0,
        ADDR_EN_CLR  = 3'd1,
        ADDR_SEL_SET = 3'd2,
        ADDR_SEL_CLR = 3'd3,
        ADDR_DIV     = 3'd4
    } cfg_addr_e;
endpackage

// File: rtl/pin_filter_cfg.sv
`timescale 1ns/1ps
module pin_filter_cfg
    import pin_filter_pkg::*;
#(
    parameter int LINES = LINES_DEF,
    parameter int DIVW  = DIVW_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] en_o,
    output logic [LINES-1:0] sel_o,
    output logic [DIVW-1:0]  div_o
);
    typedef struct packed {
        logic [LINES-1:0] en;
        logic [LINES-1:0] sel;
        logic [DIVW-1:0]  div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (cfg_addr_e'(wr_addr))
                ADDR_EN_SET:  cfg_d.en  = cfg_q.en | wr_data;
                ADDR_EN_CLR:  cfg_d.en  = cfg_q.en & ~wr_data;
                ADDR_SEL_SET: cfg_d.sel = cfg_q.sel | wr_data;
                ADDR_SEL_CLR: cfg_d.sel = cfg_q.sel & ~wr_data;
                ADDR_DIV:     cfg_d.div = wr_data[DIVW-1:0];
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o  = cfg_q.en;
    assign sel_o = cfg_q.sel;
    assign div_o = cfg_q.div;

    // R2: set and clear touch only the masked bits
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> ((en_o & $past(wr_data)) == $past(wr_data)));
    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> ((en_o & $past(wr_data)) == '0));
    p_sel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd2) |=> ((sel_o & $past(wr_data)) == $past(wr_data)));
    // R3: idle cycles leave the configuration unchanged
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_o) && $stable(en_o) && $stable(div_o)));
endmodule

// File: rtl/pin_filter_div.sv
`timescale 1ns/1ps
module pin_filter_div
    import pin_filter_pkg::*;
#(
    parameter int DIVW = DIVW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_tick,
    input  logic [DIVW-1:0] div,
    output logic            stb_o,
    output logic            dclk_o
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic            dclk;
    } div_t;

    div_t dv_d, dv_q;
    logic stb_d;

    always_comb begin
        dv_d  = dv_q;
        stb_d = 1'b0;
        if (slow_tick) begin
            if (dv_q.cnt >= div) begin
                dv_d.cnt  = '0;
                dv_d.dclk = ~dv_q.dclk;
                stb_d     = ~dv_q.dclk;
            end else begin
                dv_d.cnt = dv_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign stb_o  = stb_d;
    assign dclk_o = dv_q.dclk;

    // R7: the divided clock only moves on a slow tick
    p_dclk_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(dclk_o));
    // R7: a sample strobe is a rising edge of the divided clock
    p_stb_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> $rose(dclk_o));
endmodule

// File: rtl/pin_filter_lane.sv
`timescale 1ns/1ps
module pin_filter_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic div_stb,
    input  logic raw,
    input  logic en,
    input  logic sel,
    output logic lvl_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic gprev;
        logic gout;
        logic smp;
        logic dbout;
        logic lvl;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (clk_en) begin
            ln_d.s1    = raw;
            ln_d.s2    = ln_q.s1;
            ln_d.gprev = ln_q.s2;
            if (ln_q.s2 == ln_q.gprev) ln_d.gout = ln_q.s2;
            if (div_stb) begin
                ln_d.smp = ln_q.s2;
                if (ln_q.s2 == ln_q.smp) ln_d.dbout = ln_q.s2;
            end
            if (!en)      ln_d.lvl = ln_q.s2;
            else if (sel) ln_d.lvl = ln_q.dbout;
            else          ln_d.lvl = ln_q.gout;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign lvl_o = ln_q.lvl;

    // R8: a stopped controller clock freezes the reported level
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(lvl_o));
    // R4: bypassed line reports the synchronised sample one edge later
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !en) |=> (lvl_o == $past(ln_q.s2)));
    // R5: glitch output moves only after two equal samples
    p_glitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ln_q.gout) |-> $past(ln_q.s2 == ln_q.gprev));
    // R6: debounce output moves only on a strobe with a matching sample
    p_debounce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ln_q.dbout) |-> $past(div_stb && (ln_q.s2 == ln_q.smp)));
endmodule

// File: rtl/pin_input_filter.sv
`timescale 1ns/1ps
module pin_input_filter
    import pin_filter_pkg::*;
#(
    parameter int LINES = LINES_DEF,
    parameter int DIVW  = DIVW_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             slow_tick,
    input  logic [LINES-1:0] raw_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] pin_level,
    output logic [LINES-1:0] filt_en,
    output logic [LINES-1:0] filt_sel,
    output logic [DIVW-1:0]  div_val,
    output logic             div_clk
);
    logic div_stb;

    pin_filter_cfg #(.LINES(LINES), .DIVW(DIVW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_o    (filt_en),
        .sel_o   (filt_sel),
        .div_o   (div_val)
    );

    pin_filter_div #(.DIVW(DIVW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .div       (div_val),
        .stb_o     (div_stb),
        .dclk_o    (div_clk)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        pin_filter_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clk_en  (clk_en),
            .div_stb (div_stb),
            .raw     (raw_in[i]),
            .en      (filt_en[i]),
            .sel     (filt_sel[i]),
            .lvl_o   (pin_level[i])
        );
    end
endmodule

// File: tb/pin_input_filter_test.sv
`timescale 1ns/1ps
module pin_input_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        slow_tick = 1'b0;
    logic [31:0] raw_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] pin_level, filt_en, filt_sel;
    logic [13:0] div_val;
    logic        div_clk;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pin_input_filter uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .slow_tick(slow_tick),
        .raw_in(raw_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_level(pin_level), .filt_en(filt_en), .filt_sel(filt_sel),
        .div_val(div_val), .div_clk(div_clk)
    );

    // slow tick: one pulse every three master cycles
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            slow_tick = (c % 3 == 2);
            c++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_set(input logic [31:0] cur, input logic [31:0] m);
        return cur | m;
    endfunction

    function automatic logic [31:0] exp_clr(input logic [31:0] cur, input logic [31:0] m);
        return cur & ~m;
    endfunction

    function automatic int dclk_period(input int div, input int tick_gap);
        return 2 * (div + 1) * tick_gap;
    endfunction

    task automatic measure_dclk(output int period);
        logic prev;
        int n;
        prev = div_clk;
        do begin prev = div_clk; @(negedge clk); end while (!(div_clk && !prev));
        n = 0;
        do begin prev = div_clk; @(negedge clk); n++; end while (!(div_clk && !prev));
        period = n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] m, e_en, e_sel, v, g, a, b;
        int per;
        bit ok;
        void'($urandom(32'd1234));
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(filt_en == 0 && filt_sel == 0, "R1 cfg", filt_en | filt_sel, 0);
        chk(div_val == 0 && pin_level == 0, "R1 div/pin", {div_val, pin_level[17:0]}, 0);

        // R2 / R3 set and clear masks
        wr(3'd0, 32'h0000_00F3); e_en = exp_set(0, 32'h0000_00F3);
        wr(3'd0, 32'h8000_0100); e_en = exp_set(e_en, 32'h8000_0100);
        chk(filt_en == e_en, "R2 set", filt_en, e_en);
        wr(3'd1, 32'h8000_0021); e_en = exp_clr(e_en, 32'h8000_0021);
        chk(filt_en == e_en, "R2 clear", filt_en, e_en);
        wr(3'd2, 32'h0F0F_0000); e_sel = 32'h0F0F_0000;
        wr(3'd3, 32'h0300_0000); e_sel = exp_clr(e_sel, 32'h0300_0000);
        chk(filt_sel == e_sel, "R3 set/clear", filt_sel, e_sel);
        chk(filt_en == e_en, "R3 en untouched", filt_en, e_en);
        wr(3'd1, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);

        // R10 divider field width
        wr(3'd4, 32'hFFFF_FFFF);
        chk(div_val == 14'h3FFF, "R10 div", {18'd0, div_val}, 32'h3FFF);
        wr(3'd4, 32'd1);
        chk(div_val == 14'd1, "R10 div reload", {18'd0, div_val}, 1);

        // R7 divided clock period
        measure_dclk(per);
        chk(per == dclk_period(1, 3), "R7 div=1", per, dclk_period(1, 3));
        wr(3'd4, 32'd3);
        measure_dclk(per);
        measure_dclk(per);
        chk(per == dclk_period(3, 3), "R7 div=3", per, dclk_period(3, 3));
        wr(3'd4, 32'd1);

        // R4 bypass latency on line 4
        @(negedge clk); raw_in[4] = 1'b1;
        cyc(2);
        chk(pin_level[4] == 1'b0, "R4 early", pin_level, 0);
        cyc(1);
        chk(pin_level[4] == 1'b1, "R4 edge3", pin_level, 32'h10);
        raw_in[4] = 1'b0; cyc(5);

        // R5 glitch filter on line 1
        wr(3'd0, 32'h2);
        cyc(6);
        @(negedge clk); raw_in[1] = 1'b1;
        @(negedge clk); raw_in[1] = 1'b0;
        ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pin_level[1]) ok = 0;
        end
        chk(ok, "R5 pulse rejected", pin_level, 0);
        @(negedge clk); raw_in[1] = 1'b1;
        cyc(4);
        chk(pin_level[1] == 1'b0, "R5 edge4", pin_level, 0);
        cyc(1);
        chk(pin_level[1] == 1'b1, "R5 edge5", pin_level, 32'h2);
        raw_in[1] = 1'b0; cyc(8);

        // R6 debounce filter on line 0, sample interval 12 cycles
        wr(3'd0, 32'h1); wr(3'd2, 32'h1);
        cyc(40);
        @(negedge clk); raw_in[0] = 1'b1;
        cyc(6); raw_in[0] = 1'b0;
        ok = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pin_level[0]) ok = 0;
        end
        chk(ok, "R6 short pulse rejected", pin_level, 0);
        @(negedge clk); raw_in[0] = 1'b1;
        cyc(8);
        chk(pin_level[0] == 1'b0, "R6 not before two samples", pin_level, 0);
        cyc(32);
        chk(pin_level[0] == 1'b1, "R6 accepted", pin_level, 32'h1);

        // R8 frozen controller clock
        a = 32'hA5A5_0F0F;
        @(negedge clk); raw_in = a;
        cyc(40);
        chk(pin_level == a, "R8 settle", pin_level, a);
        clk_en = 1'b0;
        b = 32'h5A5A_F0F0;
        raw_in = b;
        cyc(30);
        chk(pin_level == a, "R8 frozen", pin_level, a);
        clk_en = 1'b1;
        cyc(40);
        chk(pin_level == b, "R8 resumed", pin_level, b);

        // R9 random configurations, levels and one-cycle glitches
        for (int it = 0; it < 20; it++) begin
            m = $urandom; v = $urandom; g = $urandom;
            wr(3'd1, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
            wr(3'd0, m); e_en = m;
            m = $urandom;
            wr(3'd2, m);
            chk(filt_sel == m && filt_en == e_en, "R3 random cfg", filt_sel, m);
            @(negedge clk); raw_in = v;
            cyc(40);
            chk(pin_level == v, "R9 settle", pin_level, v);
            @(negedge clk); raw_in = v ^ g;
            @(negedge clk); raw_in = v;
            ok = 1;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (((pin_level ^ v) & e_en) != 0) ok = 0;
            end
            chk(ok, "R9 filtered lines ignore glitch", pin_level & e_en, v & e_en);
            cyc(10);
            chk(pin_level == v, "R9 after glitch", pin_level, v);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule